// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that fetches, decodes and completes one instruction in every clock cycle. It runs a fixed subset of a classic three-format load/store instruction set: five register-to-register ALU operations, add-immediate, word load, word store, branch-if-equal and an absolute jump. The program counter, a 32-entry register file, an instruction store and a data store all live inside the block. Control is a flat combinational decode of the opcode and function fields, and it drives a 3-bit ALU operation code.

The instruction store is filled through a test-only write port while the core is held in reset. When reset is released, execution starts at address 0. Each committed register write and each data-store write is shown on a trace of output ports, so that an environment can follow the program's effects cycle by cycle. Only the program counter is reset. The register file and data store power up with unknown contents.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the PC reads 0 and no register or data-store write is issued. The release is synchronised through two flops. After that the PC advances by 4 each cycle for every instruction that is not a branch or a jump.
- R2: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A performs add/sub/and/or/signed set-less-than on the registers named in bits 25:21 and 20:16. The result goes to the register in bits 15:11.
- R3: Opcode 0x08 (add-immediate) adds the sign-extended immediate to the register in bits 25:21 and writes the sum to the register in bits 20:16.
- R4: The 16-bit immediate in bits 15:0 is sign-extended: bit 15 fills bits 31:16.
- R5: Opcode 0x23 (load) reads the data-store word at byte address rs + sext(imm). The read is combinational. The word is written to the register in bits 20:16 at the same clock edge.
- R6: Opcode 0x2B (store) writes the register in bits 20:16 to byte address rs + sext(imm) on the rising edge. It shows `dmem_we_o` with that address and data during the cycle.
- R7: Register 0 always reads as zero. A write aimed at it changes nothing and raises no `rf_we_o`.
- R8: Opcode 0x04 (branch-if-equal) sets the next PC to PC+4+(sext(imm)<<2) when both source registers are equal, and to PC+4 otherwise. Backward offsets are supported.
- R9: Opcode 0x02 (jump) sets the next PC to {(PC+4)[31:28], bits 25:0, 2'b00}.
- R10: Any other opcode, or an opcode-0x00 word with an unlisted funct, writes neither a register nor the data store, and the PC advances by 4.
- R11: The test port writes `imem_wdata_i` into instruction word `imem_addr_i` on a rising edge when `imem_we_i` is 1. The core fetches the word at PC[IAW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_we_i | input | 1 | Test-port write enable for the instruction store |
| imem_addr_i | input | IAW (6) | Test-port word address |
| imem_wdata_i | input | 32 | Test-port instruction word |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | A register write to a non-zero register commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |
| dmem_we_o | output | 1 | A data-store write commits at the next edge |
| dmem_addr_o | output | 32 | Data-store byte address (ALU result) |
| dmem_wdata_o | output | 32 | Data-store write value |

## Verification
The bench builds the core with its default 64-word instruction and data stores. That is enough room for a 26-instruction program that covers every opcode and funct, a register-0 write, a skipped forward branch, a taken backward loop, a jump over dead code and an undefined opcode. The scoreboard predicts the exact sequence of committed register and store events. Any instruction that runs when it should have been skipped, or any write that should not have happened, therefore shows up as an unexpected or mismatched event. Load data is confirmed by storing a value, loading it back and comparing the value the load commits.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN  = 32;
  localparam int RAW   = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_to_reg;
    logic    mem_we;
    logic    alu_imm;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.alu_imm = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.alu_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.alu_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default:  ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [N];
  logic         wr_en;

  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_addr_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o
);

  logic            sync_q;
  logic            run_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] sext;
  logic [XLEN-1:0] rd1;
  logic [XLEN-1:0] rd2;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic [XLEN-1:0] dmem_rdata;
  logic [XLEN-1:0] wb_data;
  logic [RAW-1:0]  wb_addr;
  logic            wb_en;
  logic            st_en;
  logic            take_br;
  ctrl_t           ctrl;

  // reset release synchroniser; run_q gates every state update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= 1'b1;
      run_q  <= sync_q;
    end
  end

  sc_ram #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (imem_we_i),
    .waddr (imem_addr_i),
    .wdata (imem_wdata_i),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_regfile #(.W(XLEN), .N(1 << RAW)) u_rf (
    .clk (clk),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (wb_en),
    .wa  (wb_addr),
    .wd  (wb_data)
  );

  assign alu_b = ctrl.alu_imm ? sext : rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign st_en = run_q && ctrl.mem_we;

  sc_ram #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (st_en),
    .waddr (alu_y[DAW+1:2]),
    .wdata (rd2),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dmem_rdata)
  );

  assign wb_en   = run_q && ctrl.reg_we;
  assign wb_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  // next-state for the program counter
  assign pc_plus4 = pc_q + 32'd4;
  assign take_br  = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)   pc_d = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (take_br) pc_d = pc_plus4 + {sext[XLEN-3:0], 2'b00};
    else             pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (run_q) pc_q <= pc_d;
  end

  assign pc_o         = pc_q;
  assign rf_we_o      = wb_en && (wb_addr != '0);
  assign rf_waddr_o   = wb_addr;
  assign rf_wdata_o   = wb_data;
  assign dmem_we_o    = st_en;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rd2;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_q,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic [31:0] rd1,
  input logic [31:0] rd2,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dmem_we_o
);

  logic [5:0]  opc;
  logic [31:0] jmp_tgt;
  logic        known;

  assign opc     = instr[31:26];
  assign jmp_tgt = {pc_q[31:28] + {3'b000, (pc_q[27:0] > 28'hFFFFFFB)}, instr[25:0], 2'b00};
  assign known   = (opc == 6'h00) || (opc == 6'h02) || (opc == 6'h04) ||
                   (opc == 6'h08) || (opc == 6'h23) || (opc == 6'h2B);

  // R1: outside run, nothing is written
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!rf_we_o && !dmem_we_o));

  // R1: sequential instructions step the PC by 4
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && opc != 6'h02 && opc != 6'h04) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7: register 0 never appears on the write trace
  p_no_r0_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  // R8: an unequal compare falls through
  p_beq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && opc == 6'h04 && rd1 != rd2) |=> (pc_q == $past(pc_q) + 32'd4));

  // R9: jump target
  p_jump_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && opc == 6'h02) |=> (pc_q == $past(jmp_tgt)));

  // R10: unknown opcodes write nothing
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !known) |-> (!rf_we_o && !dmem_we_o));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .pc_q       (pc_q),
  .instr      (instr),
  .rd1        (rd1),
  .rd2        (rd2),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dmem_we_o  (dmem_we_o)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_we_i;
  logic [5:0]  imem_addr_i;
  logic [31:0] imem_wdata_i;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        dmem_we_o;
  logic [31:0] dmem_addr_o;
  logic [31:0] dmem_wdata_o;

  always #2 clk = ~clk;

  sc_core dut (
    .clk(clk), .rst_n(rst_n), .imem_we_i(imem_we_i), .imem_addr_i(imem_addr_i),
    .imem_wdata_i(imem_wdata_i), .pc_o(pc_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dmem_we_o(dmem_we_o),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  typedef struct {
    bit          is_mem;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } ev_t;

  ev_t exp_q[$];
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'h02, word[25:0]};
  endfunction

  task automatic put_reg(int r, logic [31:0] v, string req);
    exp_q.push_back('{1'b0, 32'(r), v, req});
  endtask
  task automatic put_mem(logic [31:0] a, logic [31:0] v, string req);
    exp_q.push_back('{1'b1, a, v, req});
  endtask

  task automatic load(int idx, logic [31:0] w);
    @(negedge clk);
    imem_we_i    = 1'b1;
    imem_addr_i  = idx[5:0];
    imem_wdata_i = w;
  endtask

  // monitor: pops the scoreboard on every committed event
  always @(negedge clk) begin
    if (!done && (rf_we_o || dmem_we_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected write", dmem_we_o ? dmem_addr_o : {27'd0, rf_waddr_o}, 32'hx);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.is_mem) begin
          chk(dmem_we_o, e.req, "store expected", {31'd0, dmem_we_o}, 32'd1);
          chk(dmem_addr_o == e.addr, e.req, "store address", dmem_addr_o, e.addr);
          chk(dmem_wdata_o == e.data, e.req, "store data", dmem_wdata_o, e.data);
        end else begin
          chk(rf_we_o, e.req, "register write expected", {31'd0, rf_we_o}, 32'd1);
          chk({27'd0, rf_waddr_o} == e.addr, e.req, "dest register", {27'd0, rf_waddr_o}, e.addr);
          chk(rf_wdata_o == e.data, e.req, "write value", rf_wdata_o, e.data);
        end
      end
    end
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    imem_we_i = 1'b0;
    imem_addr_i = '0;
    imem_wdata_i = '0;
    // R11: program goes in through the test port while reset is held
    load(0,  enc_i(6'h08, 0, 1, 5));
    load(1,  enc_i(6'h08, 0, 2, -3));
    load(2,  enc_r(1, 2, 3, 6'h20));
    load(3,  enc_r(1, 2, 4, 6'h22));
    load(4,  enc_r(1, 2, 5, 6'h24));
    load(5,  enc_r(1, 2, 6, 6'h25));
    load(6,  enc_r(2, 1, 7, 6'h2A));
    load(7,  enc_r(1, 2, 8, 6'h2A));
    load(8,  enc_i(6'h2B, 1, 4, 3));
    load(9,  enc_i(6'h23, 1, 9, 3));
    load(10, enc_i(6'h08, 0, 0, 7));
    load(11, enc_i(6'h2B, 1, 0, 7));
    load(12, enc_i(6'h04, 1, 2, 5));
    load(13, enc_i(6'h04, 4, 9, 2));
    load(14, enc_i(6'h08, 0, 10, 99));
    load(15, enc_i(6'h08, 0, 10, 98));
    load(16, enc_i(6'h08, 0, 11, 16'h7FFF));
    load(17, enc_j(20));
    load(18, enc_i(6'h08, 0, 12, 1));
    load(19, enc_r(1, 1, 12, 6'h20));
    load(20, 32'hFC22_1234);
    load(21, enc_i(6'h08, 1, 1, -1));
    load(22, enc_i(6'h04, 1, 0, 1));
    load(23, enc_i(6'h04, 0, 0, -3));
    load(24, enc_i(6'h2B, 0, 11, 0));
    load(25, enc_j(25));
    @(negedge clk);
    imem_we_i = 1'b0;

    put_reg(1, 32'd5,        "R3");
    put_reg(2, 32'hFFFFFFFD, "R4");
    put_reg(3, 32'd2,        "R2");
    put_reg(4, 32'd8,        "R2");
    put_reg(5, 32'd5,        "R2");
    put_reg(6, 32'hFFFFFFFD, "R2");
    put_reg(7, 32'd1,        "R2");
    put_reg(8, 32'd0,        "R2");
    put_mem(32'd8, 32'd8,    "R6");
    put_reg(9, 32'd8,        "R5");
    put_mem(32'd12, 32'd0,   "R7");
    put_reg(11, 32'h7FFF,    "R8");
    for (int k = 4; k >= 0; k--) put_reg(1, 32'(k), "R8");
    put_mem(32'd0, 32'h7FFF, "R9");

    // R1: reset state
    chk(pc_o == 32'd0, "R1", "pc during reset", pc_o, 32'd0);
    chk(!rf_we_o && !dmem_we_o, "R1", "write during reset", {30'd0, rf_we_o, dmem_we_o}, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc_o == 32'd0, "R1", "pc held while release syncs", pc_o, 32'd0);
    repeat (80) @(negedge clk);

    chk(pc_o == 32'd100, "R9", "pc parked on self jump", pc_o, 32'd100);
    chk(exp_q.size() == 0, "R11", "events left unseen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule